// File: doc/BRIEF.md
# Tick Rate Trimmer

This block adjusts the average rate of a stream of raw timebase ticks, such as a 32,768 Hz crystal tick stream, before they reach a calendar counter. Raw ticks are grouped into fixed windows of `TICKS_PER_WIN` ticks. The default window of 1,966,080 ticks is one minute at 32,768 Hz. A 5-bit trim magnitude and a direction bit set how many ticks are adjusted in each window.

When the direction bit is 1, the block speeds the clock up by adding `ADD_PER_STEP` ticks per magnitude step. With the default of 8, that is about +4.07 ppm per step. When the direction bit is 0, it slows the clock down by removing `DROP_PER_STEP` ticks per step. With the default of 4, that is about −2.03 ppm per step. The speed-up step is therefore twice the size of the slow-down step. The full range is about +5.5 and −2.75 minutes per month.

Adjustments are spread evenly over the window by a running remainder, so they never arrive as a burst. An added tick is emitted in the idle cycle after a raw tick. A removed tick is a raw tick that is not forwarded. The tick streams are plain one-cycle pulses. There is no back-pressure: the consumer must accept every output pulse, because a tick cannot be held back.

Top module: `clkcal_trim`

## Requirements
- R1: While `rst_n` is low, `tick_out` is 0. Reset restarts the window, so the next raw tick is the first tick of a new window.
- R2: A window is `TICKS_PER_WIN` raw ticks long. `cal_mag` and `cal_fast` are sampled on the first raw tick of each window and apply to the whole of that window. Changes made later take effect from the next window.
- R3: With `cal_fast`=1, the number of `tick_out` pulses in a window equals `TICKS_PER_WIN + cal_mag*ADD_PER_STEP`.
- R4: With `cal_fast`=0, the number of `tick_out` pulses in a window equals `TICKS_PER_WIN - cal_mag*DROP_PER_STEP`. A removed tick produces no output pulse.
- R5: With `cal_mag`=0, every raw tick produces exactly one output pulse one cycle later, whatever the value of `cal_fast`.
- R6: Let K be the number of adjusted ticks in a window. After the first h raw ticks of that window, exactly floor(K*h/`TICKS_PER_WIN`) adjustments have taken place. At most one adjustment is made per raw tick.
- R7: A raw tick that is forwarded appears on `tick_out` one cycle after `tick_in`. An added tick appears on `tick_out` two cycles after the raw tick that triggered it.
- R8: Raw ticks must be separated by at least one idle cycle. `tick_in` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Raw tick pulse, one cycle wide |
| cal_mag | input | MAG_W | Trim magnitude in steps |
| cal_fast | input | 1 | Direction: 1 adds ticks (speeds up), 0 removes ticks (slows down) |
| tick_out | output | 1 | Trimmed tick pulse |

## Verification
The bench builds the block with `TICKS_PER_WIN`=256 and all other parameters at their defaults. A full window then takes under a thousand cycles. The largest speed-up setting (31 steps, 248 added ticks) still fits within one window, so both ends of the magnitude range can be counted exactly over whole windows. Half-window counts check the even spreading of adjustments. Cycle-level traces after reset check where added and removed ticks fall.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic {
    DIR_SLOW = 1'b0,
    DIR_FAST = 1'b1
  } cal_dir_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cal_win_ctr.sv
module cal_win_ctr #(
  parameter int unsigned TICKS_PER_WIN = 1966080
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic win_first
);
  localparam int unsigned CNT_W = (TICKS_PER_WIN > 2) ? $clog2(TICKS_PER_WIN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_WIN - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick_in) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign win_first = (cnt == '0);

  // raw ticks must leave an idle cycle between them
  assert_tick_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_in |=> !tick_in);

endmodule

// File: rtl/cal_spread.sv
module cal_spread
  import cal_pkg::*;
#(
  parameter int unsigned TICKS_PER_WIN = 1966080,
  parameter int unsigned MAG_W         = 5,
  parameter int unsigned ADD_PER_STEP  = 8,
  parameter int unsigned DROP_PER_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic             win_first,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_fast,
  output logic             add_evt,
  output logic             drop_evt
);
  localparam int unsigned K_MAX = ((2 ** MAG_W) - 1) * max_u(ADD_PER_STEP, DROP_PER_STEP);
  localparam int unsigned ACC_W = $clog2(TICKS_PER_WIN) + 2;
  localparam logic [ACC_W-1:0] WIN = ACC_W'(TICKS_PER_WIN);

  generate
    if (K_MAX > TICKS_PER_WIN) begin : g_bad_range
      $error("trim range exceeds one adjustment per raw tick");
    end
  endgenerate

  logic [ACC_W-1:0] step_in, k_in, k_lat, k_now, acc, sum, acc_nxt;
  cal_dir_e dir_in, dir_lat, dir_now;
  logic hit;

  assign dir_in  = cal_dir_e'(cal_fast);
  assign step_in = (dir_in == DIR_FAST) ? ACC_W'(ADD_PER_STEP) : ACC_W'(DROP_PER_STEP);
  assign k_in    = ACC_W'(cal_mag) * step_in;

  // settings taken on the first tick of a window, held for the rest
  assign k_now   = win_first ? k_in   : k_lat;
  assign dir_now = win_first ? dir_in : dir_lat;

  assign sum     = acc + k_now;
  assign hit     = (sum >= WIN);
  assign acc_nxt = hit ? (sum - WIN) : sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      k_lat   <= '0;
      dir_lat <= DIR_SLOW;
    end else if (tick_in) begin
      acc <= acc_nxt;
      if (win_first) begin
        k_lat   <= k_in;
        dir_lat <= dir_in;
      end
    end
  end

  assign add_evt  = tick_in && hit && (dir_now == DIR_FAST);
  assign drop_evt = tick_in && hit && (dir_now == DIR_SLOW);

  // every window ends with the remainder drained to zero
  assert_win_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_in && win_first) |-> (acc == '0));

  assert_one_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({add_evt, drop_evt}));

endmodule

// File: rtl/cal_tick_merge.sv
module cal_tick_merge (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic add_evt,
  input  logic drop_evt,
  output logic tick_out
);
  logic pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      tick_out <= 1'b0;
    end else begin
      tick_out <= (tick_in && !drop_evt) || (pending && !tick_in);
      pending  <= add_evt || (pending && tick_in);
    end
  end

  // one queued extra tick at a time
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    add_evt |-> !pending);

  assert_pending_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !tick_in) |=> tick_out);

endmodule

// File: rtl/clkcal_trim.sv
module clkcal_trim #(
  parameter int unsigned TICKS_PER_WIN = 1966080,
  parameter int unsigned MAG_W         = 5,
  parameter int unsigned ADD_PER_STEP  = 8,
  parameter int unsigned DROP_PER_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_fast,
  output logic             tick_out
);
  logic win_first;
  logic add_evt;
  logic drop_evt;

  cal_win_ctr #(
    .TICKS_PER_WIN(TICKS_PER_WIN)
  ) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_in  (tick_in),
    .win_first(win_first)
  );

  cal_spread #(
    .TICKS_PER_WIN(TICKS_PER_WIN),
    .MAG_W        (MAG_W),
    .ADD_PER_STEP (ADD_PER_STEP),
    .DROP_PER_STEP(DROP_PER_STEP)
  ) u_spread (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_in  (tick_in),
    .win_first(win_first),
    .cal_mag  (cal_mag),
    .cal_fast (cal_fast),
    .add_evt  (add_evt),
    .drop_evt (drop_evt)
  );

  cal_tick_merge u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_in (tick_in),
    .add_evt (add_evt),
    .drop_evt(drop_evt),
    .tick_out(tick_out)
  );

  assert_raw_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_in && !drop_evt) |=> tick_out);

  assert_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> !tick_out);

endmodule

// File: tb/sim_clkcal_trim.sv
`timescale 1ns/1ps
module sim_clkcal_trim;
  localparam int W = 256;
  localparam int NV = 10;
  localparam int VMAG  [NV] = '{0,   0,   1,   1,   5,   10,  31,  31,  16,  20};
  localparam int VFAST [NV] = '{0,   1,   1,   0,   1,   0,   1,   0,   1,   0};
  localparam int VFULL [NV] = '{256, 256, 264, 252, 296, 216, 504, 132, 384, 176};
  localparam int VHALF [NV] = '{128, 128, 132, 126, 148, 108, 252, 66,  192, 88};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_in = 1'b0;
  logic [4:0] cal_mag = '0;
  logic cal_fast = 1'b0;
  logic tick_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clkcal_trim #(.TICKS_PER_WIN(W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in),
    .cal_mag(cal_mag), .cal_fast(cal_fast), .tick_out(tick_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 out low in reset", int'(tick_out), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  // one raw tick, 3-cycle period; returns tick_out one and two cycles later
  task automatic one_tick(output int a, output int b);
    tick_in = 1'b1;
    @(posedge clk); #1;
    a = int'(tick_out);
    tick_in = 1'b0;
    @(posedge clk); #1;
    b = int'(tick_out);
    @(posedge clk); #1;
  endtask

  task automatic run_ticks(input int n, output int cnt);
    int a, b;
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      one_tick(a, b);
      cnt += a + b;
    end
  endtask

  initial begin
    int c1, c2, a, b;
    @(posedge clk); #1;
    do_reset();

    // vector walk over whole windows (R3, R4, R5, R6)
    for (int v = 0; v < NV; v++) begin
      cal_mag  = 5'(VMAG[v]);
      cal_fast = VFAST[v][0];
      run_ticks(W / 2, c1);
      run_ticks(W / 2, c2);
      check(VMAG[v] == 0 ? "R5 window count" : (VFAST[v] != 0 ? "R3 window count" : "R4 window count"),
            c1 + c2, VFULL[v]);
      check("R6 half-window count", c1, VHALF[v]);
    end

    // R2: change mid-window applies from next window
    cal_mag = 5'd5; cal_fast = 1'b1;
    run_ticks(100, c1);
    cal_mag = 5'd0;
    run_ticks(W - 100, c2);
    check("R2 held for window", c1 + c2, 296);
    run_ticks(W, c1);
    check("R2 new window", c1, 256);

    // R1: reset mid-window realigns the window
    cal_mag = 5'd8; cal_fast = 1'b1;
    run_ticks(100, c1);
    do_reset();
    run_ticks(W, c1);
    check("R1 realigned window", c1, 320);

    // R7: fast 31 steps -> first add on raw tick 1
    cal_mag = 5'd31; cal_fast = 1'b1;
    do_reset();
    one_tick(a, b);
    check("R7 raw tick 1 cycle", a, 1);
    check("R7 no extra yet", b, 0);
    one_tick(a, b);
    check("R7 raw forwarded", a, 1);
    check("R7 extra 2 cycles", b, 1);

    // R4: slow 31 steps -> first drop on raw tick 2
    cal_fast = 1'b0;
    do_reset();
    one_tick(a, b);
    check("R4 tick0 kept", a, 1);
    one_tick(a, b);
    check("R4 tick1 kept", a, 1);
    one_tick(a, b);
    check("R4 tick2 dropped", a + b, 0);

    // R5: magnitude 0 passes with one-cycle latency in both directions
    cal_mag = 5'd0; cal_fast = 1'b1;
    do_reset();
    one_tick(a, b);
    check("R5 pass fast", a * 2 + b, 2);
    cal_fast = 1'b0;
    one_tick(a, b);
    check("R5 pass slow", a * 2 + b, 2);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule